// File: doc/BRIEF.md
# Bus Input Buffer Power Controller

This block decides, cycle by cycle, which receive buffers and which termination legs of a shared front-side bus interface need to be powered. Three separate protocol conditions each gate their own group. The data-bus receivers are awake only while the data power request is asserted, plus one trailing cycle so the final beat is caught. The address and control receivers are awake only while another agent holds a priority request. Termination is removed from any pin that the local agent itself is pulling low. A parking flag also tells the peer agent that the local request has been released, so that the peer can put its own address and control receivers to sleep.

The three active-low handshake inputs are brought in through two-flop synchronizers on the bus clock before they are used. The per-pin drive enable and drive value come from the local transmit logic in the same clock domain, so they act combinationally. While reset is asserted, every enable is held on and parking is held off. A test override input forces all receivers on and suppresses parking, and it leaves termination to the drive rule.

Top module: `bus_buf_pwr_ctl`

## Requirements
- R1: While rstN is low, dataBufEn, addrBufEn and every bit of termEn are 1 and parkInd is 0, whatever the other inputs are.
- R2: Out of reset and without override, dataBufEn rises after the second rising clock edge at which dataPwrReqN has been sampled 0, and it is 0 once the request has been sampled 1 for long enough that neither the synchronized request nor the tail cycle is active.
- R3: After the synchronized data power request drops, dataBufEn stays 1 for exactly one more clock cycle, so a request lasting a single sampled cycle yields an enable that lasts two cycles.
- R4: Out of reset and without override, addrBufEn equals the inverse of prioReqN as it was sampled two rising edges earlier (1 when another agent holds priority, 0 when it does not).
- R5: Out of reset, termEn[i] is 0 in the same cycle in which padDriveEn[i] is 1 and padDriveVal[i] is 0, and it is 1 for the other three combinations of those two bits, for each pin separately.
- R6: Out of reset and without override, parkInd equals busReqN as it was sampled two rising edges earlier (1 when the local request is released, 0 while it is held).
- R7: testForceOn = 1 makes dataBufEn and addrBufEn 1 and parkInd 0 without delay, and it does not change termEn.
- R8: Each of the data, address and parking outputs depends only on its own request input, so any combination of the three requests gives the outputs that R2 to R6 predict separately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testForceOn | input | 1 | Test override that forces all receivers on |
| dataPwrReqN | input | 1 | Active-low data power request |
| prioReqN | input | 1 | Active-low priority request from another agent |
| busReqN | input | 1 | Active-low bus request of the local agent |
| padDriveEn | input | NPINS | Local agent is driving pin i |
| padDriveVal | input | NPINS | Value the local agent drives on pin i |
| dataBufEn | output | 1 | Data-bus input buffer enable |
| addrBufEn | output | 1 | Address and control input buffer enable |
| parkInd | output | 1 | Local request released, peer may park |
| termEn | output | NPINS | Per-pin on-die termination enable |

## Verification
All sixteen combinations of the three request lines and the override are held for several cycles. This shows whether the paths are independent and whether each output waits the two-edge synchronizer delay. Data requests are then given as pulses of one to four cycles separated by gaps of one to three cycles, which separates a correct single-cycle tail from a missing tail or a longer one and shows whether back-to-back pulses merge properly. Every pairing of drive enable and drive value over four pins is swept with and without the override. This shows that only the pin being pulled low loses termination and that the override does not affect termination. Reset is applied in the middle of activity to show that it forces the safe state at once.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

  // Strobes from the control side to the enable datapath.
  typedef struct packed {
    logic dataOn;   // data receivers awake
    logic addrOn;   // address/control receivers awake
    logic parkOn;   // local request released
    logic termAll;  // hold every termination leg on
  } bbpStrobe_t;

endpackage

// File: rtl/bbp_sync.sv
module bbp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[LAST];

endmodule

// File: rtl/bbp_ctrl.sv
module bbp_ctrl
  import bbp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       testForceOn,
  input  logic       syncDataReqN,
  input  logic       syncPrioReqN,
  input  logic       syncBusReqN,
  output bbpStrobe_t strobe
);

  logic dataReq;
  logic tailQ;
  logic forceAll;

  assign dataReq  = ~syncDataReqN;
  assign forceAll = testForceOn | ~rstN;

  // One trailing cycle after the request drops covers the last beat.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tailQ <= 1'b0;
    else       tailQ <= dataReq;
  end

  always_comb begin
    strobe.dataOn  = forceAll | dataReq | tailQ;
    strobe.addrOn  = forceAll | ~syncPrioReqN;
    strobe.parkOn  = ~forceAll & syncBusReqN;
    strobe.termAll = ~rstN;
  end

  AST_DATA_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReq) |-> strobe.dataOn); // R3

  AST_DATA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!testForceOn && !dataReq && !$past(dataReq)) |-> !strobe.dataOn); // R2

endmodule

// File: rtl/bbp_datapath.sv
module bbp_datapath
  import bbp_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bbpStrobe_t       strobe,
  input  logic [NPINS-1:0] padDriveEn,
  input  logic [NPINS-1:0] padDriveVal,
  output logic             dataBufEn,
  output logic             addrBufEn,
  output logic             parkInd,
  output logic [NPINS-1:0] termEn
);

  assign dataBufEn = strobe.dataOn;
  assign addrBufEn = strobe.addrOn;
  assign parkInd   = strobe.parkOn;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic pullingLow;
    assign pullingLow = padDriveEn[i] & ~padDriveVal[i];
    assign termEn[i]  = strobe.termAll | ~pullingLow;

    AST_TERM_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (padDriveEn[i] && !padDriveVal[i]) |-> !termEn[i]); // R5

    AST_TERM_ON_ELSE: assert property (@(posedge clk) disable iff (!rstN)
      (!padDriveEn[i] || padDriveVal[i]) |-> termEn[i]); // R5
  end

endmodule

// File: rtl/bus_buf_pwr_ctl.sv
module bus_buf_pwr_ctl
  import bbp_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testForceOn,
  input  logic             dataPwrReqN,
  input  logic             prioReqN,
  input  logic             busReqN,
  input  logic [NPINS-1:0] padDriveEn,
  input  logic [NPINS-1:0] padDriveVal,
  output logic             dataBufEn,
  output logic             addrBufEn,
  output logic             parkInd,
  output logic [NPINS-1:0] termEn
);

  localparam int NREQ = 3;

  logic [NREQ-1:0] rawReqN;
  logic [NREQ-1:0] syncReqN;
  bbpStrobe_t      strobe;

  assign rawReqN = {busReqN, prioReqN, dataPwrReqN};

  bbp_sync #(
    .WIDTH    (NREQ),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({NREQ{1'b1}})
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawReqN),
    .dout(syncReqN)
  );

  bbp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .testForceOn (testForceOn),
    .syncDataReqN(syncReqN[0]),
    .syncPrioReqN(syncReqN[1]),
    .syncBusReqN (syncReqN[2]),
    .strobe      (strobe)
  );

  bbp_datapath #(.NPINS(NPINS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .padDriveEn (padDriveEn),
    .padDriveVal(padDriveVal),
    .dataBufEn  (dataBufEn),
    .addrBufEn  (addrBufEn),
    .parkInd    (parkInd),
    .termEn     (termEn)
  );

  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rstN)
    testForceOn |-> (dataBufEn && addrBufEn && !parkInd)); // R7

  if (SYNC_STAGES == 2) begin : g_lat
    AST_ADDR_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN, 2) && $past(rstN) && !testForceOn)
        |-> (addrBufEn == !$past(prioReqN, 2))); // R4

    AST_PARK_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN, 2) && $past(rstN) && !testForceOn)
        |-> (parkInd == $past(busReqN, 2))); // R6
  end

endmodule

// File: tb/bus_buf_pwr_ctl_bench.sv
`timescale 1ns/1ps
module bus_buf_pwr_ctl_bench;

  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN;
  logic testForceOn, dataPwrReqN, prioReqN, busReqN;
  logic [NP-1:0] padDriveEn, padDriveVal;
  logic dataBufEn, addrBufEn, parkInd;
  logic [NP-1:0] termEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model of the two-edge synchronizer and the tail cycle
  logic d1, d2, tl, p1, p2, b1, b2;

  always #2.5 clk = ~clk;

  bus_buf_pwr_ctl #(.NPINS(NP)) u_bus_buf_pwr_ctl (
    .clk(clk), .rstN(rstN), .testForceOn(testForceOn),
    .dataPwrReqN(dataPwrReqN), .prioReqN(prioReqN), .busReqN(busReqN),
    .padDriveEn(padDriveEn), .padDriveVal(padDriveVal),
    .dataBufEn(dataBufEn), .addrBufEn(addrBufEn), .parkInd(parkInd),
    .termEn(termEn)
  );

  task automatic check(input string req, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic on;
    logic [NP-1:0] expTerm;
    on = testForceOn | ~rstN;
    for (int i = 0; i < NP; i++)
      expTerm[i] = ~rstN | ~(padDriveEn[i] & ~padDriveVal[i]);
    check(rstN ? "R2/R3 dataBufEn" : "R1 dataBufEn", {{(NP-1){1'b0}}, dataBufEn},
          {{(NP-1){1'b0}}, on | d2 | tl});
    check(rstN ? "R4/R8 addrBufEn" : "R1 addrBufEn", {{(NP-1){1'b0}}, addrBufEn},
          {{(NP-1){1'b0}}, on | p2});
    check(rstN ? "R6/R7 parkInd" : "R1 parkInd", {{(NP-1){1'b0}}, parkInd},
          {{(NP-1){1'b0}}, ~on & ~b2});
    check(rstN ? "R5/R7 termEn" : "R1 termEn", termEn, expTerm);
  endtask

  // one clock: update the model at the edge, then sample 1 ns later
  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      {d1, d2, tl, p1, p2, b1, b2} = '0;
    end else begin
      tl = d2; d2 = d1; d1 = ~dataPwrReqN;
      p2 = p1; p1 = ~prioReqN;
      b2 = b1; b1 = ~busReqN;
    end
    #1;
    checkAll();
    @(negedge clk);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    {d1, d2, tl, p1, p2, b1, b2} = '0;
    rstN = 1'b0;
    testForceOn = 1'b0;
    dataPwrReqN = 1'b0; prioReqN = 1'b0; busReqN = 1'b0;
    padDriveEn = '1; padDriveVal = '0;
    #1;
    checkAll();                       // R1 before any edge
    @(negedge clk);
    tick(); tick();                   // R1 held under reset
    rstN = 1'b1;
    dataPwrReqN = 1'b1; prioReqN = 1'b1; busReqN = 1'b1;
    padDriveEn = '0;
    repeat (3) tick();

    // R8: every request combination with and without override
    for (int c = 0; c < 16; c++) begin
      dataPwrReqN = c[0]; prioReqN = c[1]; busReqN = c[2]; testForceOn = c[3];
      repeat (4) tick();
    end
    testForceOn = 1'b0;
    {dataPwrReqN, prioReqN, busReqN} = 3'b111;
    repeat (3) tick();

    // R2/R3: data pulses of width 1..4 with gaps 1..3
    for (int w = 1; w <= 4; w++) begin
      for (int g = 1; g <= 3; g++) begin
        dataPwrReqN = 1'b0;
        repeat (w) tick();
        dataPwrReqN = 1'b1;
        repeat (g) tick();
      end
    end
    repeat (4) tick();

    // R5/R7: every drive pattern over all pins, override off and on
    for (int f = 0; f < 2; f++) begin
      testForceOn = f[0];
      for (int v = 0; v < 256; v++) begin
        padDriveEn = v[3:0]; padDriveVal = v[7:4];
        #1; checkAll();
        if (v % 32 == 0) tick();
      end
    end
    testForceOn = 1'b0;

    // R1: reset in the middle of activity
    dataPwrReqN = 1'b0; prioReqN = 1'b0; busReqN = 1'b1;
    padDriveEn = '1; padDriveVal = 4'b0101;
    repeat (3) tick();
    rstN = 1'b0;
    #1; checkAll();
    tick();
    rstN = 1'b1;
    repeat (4) tick();

    finish();
  end

endmodule